// File: doc/BRIEF.md
# Absolute Address Physical Mapper

This block converts an absolute address into a physical address while virtual translation is switched off. It takes a 64-bit absolute address with two mode flags. The wide flag selects the 64-bit addressing view. The architecture flag tells a 64-bit processor apart from the legacy 32-bit one. A valid strobe qualifies each request.

One cycle after the strobe, the block registers the result. The result has three parts: a 64-bit physical address, a 2-bit region tag and a fixed permission vector. The physical address is scaled to a parameterised implemented width `PA_W`, which defaults to 40 and must lie in 33..54.

In the narrow view on a 64-bit processor, the top two nibbles of the 32-bit offset pick one of three regions: ordinary memory, I/O, or the firmware window. Each region widens the offset in its own way. A load/store pipeline places the block beside its translation path and selects this result whenever translation is disabled.

Top module: `abs_phys_map`

## Requirements
- R1: With `wide_mode`=1, `out_phys` equals `in_abs_addr[PA_W-1:0]` sign-extended from bit PA_W-1 to 64 bits, and `out_region` is 0 (memory). This holds for either value of `arch64`.
- R2: With `wide_mode`=0 and `arch64`=1, when `in_abs_addr[31:28]` is not 4'hF, `out_phys` is `{32'h0, in_abs_addr[31:0]}` and `out_region` is 0.
- R3: With `wide_mode`=0 and `arch64`=1, when `in_abs_addr[31:28]`=4'hF and `in_abs_addr[27:24]`≠0, `out_phys` is `{32'hFFFF_FFFF, in_abs_addr[31:0]}` and `out_region` is 1 (I/O).
- R4: With `wide_mode`=0 and `arch64`=1, when `in_abs_addr[31:24]`=8'hF0, `out_phys` is `{32'h0, in_abs_addr[31:0]}` with every bit from PA_W-4 to 63 set to one, and `out_region` is 2 (firmware).
- R5: With `wide_mode`=0 and `arch64`=0, `out_phys` is `{32'h0, in_abs_addr[31:0]}` and `out_region` is 0, whatever the top nibbles are.
- R6: In narrow mode, bits 63:32 of `in_abs_addr` have no effect on `out_phys` or `out_region`.
- R7: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. The result of that request appears in the same cycle.
- R8: While `in_valid` is low, `out_phys` and `out_region` keep their last values.
- R9: After reset, `out_valid`=0, `out_phys`=0 and `out_region`=0. Region code 3 never appears.
- R10: `out_perm` (bit 2 read, bit 1 write, bit 0 execute) is always 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_abs_addr | input | 64 | Absolute address |
| wide_mode | input | 1 | 1 selects the 64-bit addressing view |
| arch64 | input | 1 | 1 for 64-bit processor, 0 for legacy 32-bit |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_phys | output | 64 | Physical address |
| out_region | output | 2 | 0 memory, 1 I/O, 2 firmware |
| out_perm | output | 3 | Read/write/execute grant |

## Verification
The only state in the block is the output register. A wrong value there shows at the ports in the first cycle after the request. It appears as a wrong region code, a wrong upper fill of the address, or a strobe in the wrong cycle.

A fault in the hold logic stays invisible until the next idle cycle. The bench compares the outputs again after an idle cycle with fresh junk on the inputs. Region boundaries such as 0xEFFFFFFF, 0xF0FFFFFF and 0xF1000000 expose an off-by-one in the nibble decode immediately.

// File: rtl/apm_pkg.sv
package apm_pkg;
    localparam int ABS_W  = 64;
    localparam int PHYS_W = 64;
    localparam int OFS_W  = 32;
    localparam int NIB_W  = 4;

    typedef enum logic [1:0] {
        REG_MEM = 2'd0,
        REG_IO  = 2'd1,
        REG_FW  = 2'd2
    } region_e;

    typedef struct packed {
        logic              vld;
        logic [PHYS_W-1:0] phys;
        region_e           region;
    } map_state_t;
endpackage

// File: rtl/apm_wide.sv
module apm_wide
    import apm_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [PA_W-1:0]   addr_lo,
    output logic [PHYS_W-1:0] phys
);
    localparam int FILL_W = PHYS_W - PA_W;

    always_comb begin
        phys = {{FILL_W{addr_lo[PA_W-1]}}, addr_lo};
    end
endmodule

// File: rtl/apm_narrow.sv
module apm_narrow
    import apm_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic [OFS_W-1:0]  ofs,
    input  logic              arch64,
    output logic [PHYS_W-1:0] phys,
    output region_e           region
);
    localparam int HI_LSB  = OFS_W - NIB_W;
    localparam int MID_LSB = OFS_W - 2 * NIB_W;
    localparam int FW_BIT  = PA_W - NIB_W;
    localparam logic [PHYS_W-1:0] FW_MASK = ~((PHYS_W'(1) << FW_BIT) - PHYS_W'(1));
    localparam int EXT_W   = PHYS_W - OFS_W;

    logic hi_all_ones;
    logic mid_zero;
    logic [PHYS_W-1:0] zext;

    always_comb begin
        hi_all_ones = &ofs[OFS_W-1:HI_LSB];
        mid_zero    = ~|ofs[HI_LSB-1:MID_LSB];
        zext        = {{EXT_W{1'b0}}, ofs};
        phys        = zext;
        region      = REG_MEM;
        if (arch64 && hi_all_ones) begin
            if (!mid_zero) begin
                phys   = {{EXT_W{ofs[OFS_W-1]}}, ofs};
                region = REG_IO;
            end else begin
                phys   = zext | FW_MASK;
                region = REG_FW;
            end
        end
    end
endmodule

// File: rtl/abs_phys_map.sv
module abs_phys_map
    import apm_pkg::*;
#(
    parameter int PA_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ABS_W-1:0]  in_abs_addr,
    input  logic              wide_mode,
    input  logic              arch64,
    output logic              out_valid,
    output logic [PHYS_W-1:0] out_phys,
    output logic [1:0]        out_region,
    output logic [2:0]        out_perm
);
    localparam int FW_BIT = PA_W - NIB_W;

    generate
        if (PA_W > 54 || PA_W <= OFS_W) begin : g_bad_width
            $error("PA_W must lie in 33..54");
        end
    endgenerate

    logic [PHYS_W-1:0] wide_phys;
    logic [PHYS_W-1:0] nar_phys;
    region_e           nar_region;
    map_state_t        st_d, st_q;

    apm_wide #(.PA_W(PA_W)) u_wide (
        .addr_lo (in_abs_addr[PA_W-1:0]),
        .phys    (wide_phys)
    );

    apm_narrow #(.PA_W(PA_W)) u_narrow (
        .ofs    (in_abs_addr[OFS_W-1:0]),
        .arch64 (arch64),
        .phys   (nar_phys),
        .region (nar_region)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.phys   = wide_mode ? wide_phys : nar_phys;
            st_d.region = wide_mode ? REG_MEM : nar_region;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, phys: '0, region: REG_MEM};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_phys   = st_q.phys;
    assign out_region = st_q.region;
    assign out_perm   = 3'b111;

    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r9_region_legal: assert property (@(posedge clk) disable iff (!rst_n)
        out_region != 2'd3);
    a_r3_io_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_region == REG_IO) |-> (&out_phys[PHYS_W-1:OFS_W]));
    a_r4_fw_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_region == REG_FW) |-> (&out_phys[PHYS_W-1:FW_BIT]));
    a_r5_legacy_zext: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode && !arch64) |=>
            (out_region == REG_MEM && out_phys[PHYS_W-1:OFS_W] == '0));
    a_r1_wide_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide_mode) |=>
            (out_region == REG_MEM &&
             out_phys[PA_W-1:0] == $past(in_abs_addr[PA_W-1:0])));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_phys) && $stable(out_region)));
endmodule

// File: tb/abs_phys_map_tb.sv
module abs_phys_map_tb;
    localparam int PA_W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_abs_addr = '0;
    logic        wide_mode = 1'b0;
    logic        arch64 = 1'b0;
    logic        out_valid;
    logic [63:0] out_phys;
    logic [1:0]  out_region;
    logic [2:0]  out_perm;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    abs_phys_map #(.PA_W(PA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_abs_addr(in_abs_addr),
        .wide_mode(wide_mode), .arch64(arch64), .out_valid(out_valid),
        .out_phys(out_phys), .out_region(out_region), .out_perm(out_perm)
    );

    function automatic logic [63:0] exp_phys(logic [63:0] a, logic w, logic a64);
        logic [63:0] z;
        z = {32'h0, a[31:0]};
        if (w) return {{(64-PA_W){a[PA_W-1]}}, a[PA_W-1:0]};
        if (!a64 || a[31:28] != 4'hF) return z;
        if (a[27:24] != 4'h0) return {32'hFFFF_FFFF, a[31:0]};
        return z | ~((64'd1 << (PA_W-4)) - 64'd1);
    endfunction

    function automatic logic [1:0] exp_region(logic [63:0] a, logic w, logic a64);
        if (w || !a64 || a[31:28] != 4'hF) return 2'd0;
        if (a[27:24] != 4'h0) return 2'd1;
        return 2'd2;
    endfunction

    function automatic string req_of(logic [63:0] a, logic w, logic a64);
        if (w) return "R1";
        if (!a64) return "R5";
        if (a[31:28] != 4'hF) return "R2";
        if (a[27:24] != 4'h0) return "R3";
        return "R4";
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(logic [63:0] a, logic w, logic a64, bit test_hold);
        logic [63:0] ep;
        logic [1:0]  er;
        string       rq;
        ep = exp_phys(a, w, a64);
        er = exp_region(a, w, a64);
        rq = req_of(a, w, a64);
        @(negedge clk);
        in_valid = 1'b1; in_abs_addr = a; wide_mode = w; arch64 = a64;
        @(negedge clk);
        in_valid = 1'b0;
        in_abs_addr = {$urandom, $urandom};
        wide_mode = 1'($urandom); arch64 = 1'($urandom);
        chk(out_valid == 1'b1, "R7", 64'(out_valid), 64'd1);
        chk(out_phys == ep, rq, out_phys, ep);
        chk(out_region == er, rq, 64'(out_region), 64'(er));
        chk(out_perm == 3'b111, "R10", 64'(out_perm), 64'h7);
        if (test_hold) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R7", 64'(out_valid), 64'd0);
            chk(out_phys == ep, "R8", out_phys, ep);
            chk(out_region == er, "R8", 64'(out_region), 64'(er));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(out_valid == 1'b0, "R9", 64'(out_valid), 64'd0);
        chk(out_phys == 64'd0, "R9", out_phys, 64'd0);
        chk(out_region == 2'd0, "R9", 64'(out_region), 64'd0);
        rst_n = 1'b1;
        void'($urandom(32'h5EED_0042));

        // R1 wide mode, both signs, both architectures
        apply(64'hDEAD_BEEF_8012_3456, 1'b1, 1'b1, 1'b1);
        apply(64'hFFFF_FF7F_FFFF_FFFF, 1'b1, 1'b0, 1'b0);
        apply(64'h0000_0080_0000_0000, 1'b1, 1'b1, 1'b0);
        // R2 memory boundary
        apply(64'h0000_0000_EFFF_FFFF, 1'b0, 1'b1, 1'b1);
        apply(64'h0000_0000_0000_0000, 1'b0, 1'b1, 1'b0);
        // R3 I/O boundaries
        apply(64'h0000_0000_F100_0000, 1'b0, 1'b1, 1'b1);
        apply(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b1, 1'b0);
        // R4 firmware boundaries
        apply(64'h0000_0000_F000_0000, 1'b0, 1'b1, 1'b1);
        apply(64'h0000_0000_F0FF_FFFF, 1'b0, 1'b1, 1'b0);
        // R5 legacy ignores top nibbles
        apply(64'h0000_0000_F000_0000, 1'b0, 1'b0, 1'b1);
        apply(64'h0000_0000_F800_0001, 1'b0, 1'b0, 1'b0);
        // R6 upper junk in narrow mode
        apply(64'hA5A5_A5A5_F000_1234, 1'b0, 1'b1, 1'b0);
        apply(64'h1234_5678_F200_0000, 1'b0, 1'b1, 1'b0);
        apply(64'hFFFF_FFFF_0000_0010, 1'b0, 1'b1, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] a;
            int sel;
            a = {$urandom, $urandom};
            sel = int'($urandom_range(0, 3));
            if (sel == 1) a[31:28] = 4'hF;
            if (sel == 2) a[31:24] = 8'hF0;
            apply(a, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) != 0),
                  1'($urandom_range(0, 1)));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule